// File: doc/BRIEF.md
# Fractional Clock-Enable Generator with Half-Step Predivider

This block turns a fast parent clock into a stream of one-cycle enable pulses whose average rate is a programmed fraction of the parent rate. Two stages run in series. The first is a predivider whose divide ratio moves in steps of one half. The second is an optional M/N stage: it passes m out of every n predivided ticks. A second output gives a toggling level for the dual-edge setting. Downstream logic can use that level to carry the rate on both of its edges.

The settings come straight from a configuration register bank. The divider field h gives a ratio of (h+1)/2, and h = 0 bypasses the predivider. The M field holds m as a plain value. The N field holds the bitwise inverse of (n − m), so the block recovers n as (~N & mask) + m. A non-zero mode field turns the M/N stage on. Mode value 2 selects dual-edge output, and only when n is non-zero and m differs from n. New settings are taken only at the end of an output period, so no period is ever cut short. The new settings govern the cycle in which they are taken, so the first new period has its full programmed length.

Top module: `mnd_frac_clkgen`

## Requirements
- R1: While reset is asserted, out_en and out_tgl are both 0.
- R2: With h = 0 and mode = 0, out_en is high in every cycle.
- R3: With h ≥ 1 and mode = 0, out_en pulses exactly twice in every h+1 consecutive cycles once the settings have been taken.
- R4: When h+1 is odd, the gaps between pulses alternate between floor((h+1)/2) and ceil((h+1)/2) cycles, and each pair of neighbouring gaps adds up to h+1.
- R5: With the mode field non-zero, and n = (~N & mask) + m non-zero, out_en pulses exactly m times for every n predivided ticks. The mask holds the MW low bits.
- R6: With mode = 0, or with n = 0 (m = 0 and N all ones), the M/N stage is bypassed and every predivided tick becomes a pulse.
- R7: With the M/N stage on and m = 0, no pulse is produced, yet a new setting is still taken and pulses then resume.
- R8: A setting changed part-way through an output period does not shorten that period. The next pulse arrives at the old period length.
- R9: A setting is taken in the cycle that follows a pulse and counts from that cycle. The first new gap therefore equals the new period. This holds also when the change arrives in that very cycle.
- R10: In mode 2 with m < n, out_tgl toggles once with every pulse. In every other case out_tgl stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | HW | Half-step divider field h, giving a ratio of (h+1)/2 (0 = bypass) |
| cfg_mode | input | 2 | M/N mode: 0 off, 2 dual-edge, 1 or 3 single-edge |
| cfg_m | input | MW | M value, plain |
| cfg_n | input | MW | Inverse of (n − m) |
| out_en | output | 1 | One-cycle enable pulse per output period |
| out_tgl | output | 1 | Toggle level for dual-edge mode, 0 otherwise |

## Verification
Taking a new setting and ending a period fall in the same cycle. In that cycle the accumulators must restart under the new setting and also advance one step. The bench provokes this by driving a new setting in the very cycle it sees a pulse. It then requires the next gap to equal exactly the new period length, so a lost cycle or a doubled step would show. A second directed case changes the setting in the middle of a long period. It judges the period boundary by requiring the current gap to keep its old length and the gap after it to take the new length.

// File: rtl/mnd_pkg.sv
package mnd_pkg;
  typedef enum logic [1:0] {
    MN_OFF        = 2'd0,
    MN_SINGLE     = 2'd1,
    MN_DUAL       = 2'd2,
    MN_SINGLE_ALT = 2'd3
  } mn_mode_e;
endpackage

// File: rtl/mnd_mn_decode.sv
module mnd_mn_decode #(
  parameter int MW = 8
) (
  input  logic [1:0]  mode_i,
  input  logic [MW-1:0] m_i,
  input  logic [MW-1:0] ninv_i,
  output logic [MW:0] n_eff_o,
  output logic        active_o,
  output logic        dual_o
);
  import mnd_pkg::*;

  always_comb begin
    n_eff_o  = {1'b0, ~ninv_i} + {1'b0, m_i};
    active_o = (mode_i != MN_OFF) && (n_eff_o != '0);
    dual_o   = (mode_i == MN_DUAL) && active_o && ({1'b0, m_i} != n_eff_o);
  end
endmodule

// File: rtl/mnd_halfstep_pre.sv
module mnd_halfstep_pre #(
  parameter int HW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [HW-1:0] div_h,
  output logic          tick
);
  localparam int AW = HW + 2;

  logic [AW-1:0] acc_q, acc_d, base, sum, lim;

  always_comb begin
    base = restart ? '0 : acc_q;
    sum  = base + AW'(2);
    lim  = {2'b00, div_h} + AW'(1);
    if (div_h == '0) begin
      tick  = 1'b1;
      acc_d = '0;
    end else if (sum >= lim) begin
      tick  = 1'b1;
      acc_d = sum - lim;
    end else begin
      tick  = 1'b0;
      acc_d = sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // R3: the half-step residue never reaches the divide limit
  p_pre_acc_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && div_h != '0) |-> (acc_q <= {2'b00, div_h}));

  // R4: a ratio of 2 or more never yields two ticks in a row
  p_no_adjacent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (div_h >= HW'(3) && tick) |=> (restart || !tick));
endmodule

// File: rtl/mnd_mn_accum.sv
module mnd_mn_accum #(
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          step,
  input  logic          active,
  input  logic [MW-1:0] m_val,
  input  logic [MW:0]   n_val,
  output logic          pulse
);
  localparam int AW = MW + 2;

  logic [AW-1:0] acc_q, acc_d, base, sum, n_ext;

  always_comb begin
    base  = restart ? '0 : acc_q;
    sum   = base + {2'b00, m_val};
    n_ext = {1'b0, n_val};
    pulse = 1'b0;
    acc_d = base;
    if (!active) begin
      pulse = step;
      acc_d = '0;
    end else if (step) begin
      if (sum >= n_ext) begin
        pulse = 1'b1;
        acc_d = sum - n_ext;
      end else begin
        acc_d = sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // R5: the fractional residue stays below n while the stage is on
  p_mn_acc_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !restart) |-> (acc_q < {1'b0, n_val}));

  // R6: a bypassed stage passes every tick straight through
  p_bypass_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!active) |-> (pulse == step));
endmodule

// File: rtl/mnd_frac_clkgen.sv
module mnd_frac_clkgen #(
  parameter int HW = 5,
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] cfg_div,
  input  logic [1:0]    cfg_mode,
  input  logic [MW-1:0] cfg_m,
  input  logic [MW-1:0] cfg_n,
  output logic          out_en,
  output logic          out_tgl
);
  localparam int NW = MW + 1;

  // shadow (active) settings
  logic [HW-1:0] h_q, h_d;
  logic [1:0]    mode_q, mode_d;
  logic [MW-1:0] m_q, m_d, ninv_q, ninv_d;
  logic          fresh_q;
  logic          en_q, en_d, tgl_q, tgl_d;

  logic [NW-1:0] sh_n, ef_n;
  logic          sh_active, sh_dual, ef_active, ef_dual;
  logic          boundary, changed, do_load;
  logic [HW-1:0] ef_h;
  logic [1:0]    ef_mode;
  logic [MW-1:0] ef_m, ef_ninv;
  logic          tick, pulse;

  mnd_mn_decode #(.MW(MW)) u_dec_shadow (
    .mode_i(mode_q), .m_i(m_q), .ninv_i(ninv_q),
    .n_eff_o(sh_n), .active_o(sh_active), .dual_o(sh_dual)
  );

  always_comb begin
    boundary = en_q | fresh_q | (sh_active & (m_q == '0));
    changed  = {cfg_div, cfg_mode, cfg_m, cfg_n} != {h_q, mode_q, m_q, ninv_q};
    do_load  = boundary & changed;
    ef_h     = do_load ? cfg_div  : h_q;
    ef_mode  = do_load ? cfg_mode : mode_q;
    ef_m     = do_load ? cfg_m    : m_q;
    ef_ninv  = do_load ? cfg_n    : ninv_q;
  end

  mnd_mn_decode #(.MW(MW)) u_dec_eff (
    .mode_i(ef_mode), .m_i(ef_m), .ninv_i(ef_ninv),
    .n_eff_o(ef_n), .active_o(ef_active), .dual_o(ef_dual)
  );

  mnd_halfstep_pre #(.HW(HW)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(do_load), .div_h(ef_h), .tick(tick)
  );

  mnd_mn_accum #(.MW(MW)) u_mn (
    .clk(clk), .rst_n(rst_n), .restart(do_load), .step(tick),
    .active(ef_active), .m_val(ef_m), .n_val(ef_n), .pulse(pulse)
  );

  always_comb begin
    h_d    = ef_h;
    mode_d = ef_mode;
    m_d    = ef_m;
    ninv_d = ef_ninv;
    en_d   = pulse;
    tgl_d  = ef_dual ? ((do_load ? 1'b0 : tgl_q) ^ pulse) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q     <= '0;
      mode_q  <= '0;
      m_q     <= '0;
      ninv_q  <= '0;
      fresh_q <= 1'b1;
      en_q    <= 1'b0;
      tgl_q   <= 1'b0;
    end else begin
      h_q     <= h_d;
      mode_q  <= mode_d;
      m_q     <= m_d;
      ninv_q  <= ninv_d;
      fresh_q <= 1'b0;
      en_q    <= en_d;
      tgl_q   <= tgl_d;
    end
  end

  assign out_en  = en_q;
  assign out_tgl = tgl_q;

  // R8: settings move only at a period boundary
  p_load_at_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> ($stable(h_q) && $stable(mode_q) && $stable(m_q) && $stable(ninv_q)));

  // R10: toggle stays low outside dual-edge mode
  p_tgl_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_dual |-> !out_tgl);

  // R10: toggle rises only together with a pulse
  p_tgl_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_tgl) |-> out_en);

  // R5: the recovered n is never below m while the stage is on
  p_m_le_n_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sh_active |-> ({1'b0, m_q} <= sh_n));
endmodule

// File: tb/mnd_frac_clkgen_bench.sv
`timescale 1ns/1ps
module mnd_frac_clkgen_bench;
  localparam int HW = 5;
  localparam int MW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [HW-1:0] cfg_div;
  logic [1:0]    cfg_mode;
  logic [MW-1:0] cfg_m, cfg_n;
  logic          out_en, out_tgl;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  mnd_frac_clkgen #(.HW(HW), .MW(MW)) u_mnd_frac_clkgen (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_mode(cfg_mode),
    .cfg_m(cfg_m), .cfg_n(cfg_n), .out_en(out_en), .out_tgl(out_tgl)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drives the fields; n is given as the effective n
  task automatic set_cfg(input int h, input int mode, input int m, input int n);
    cfg_div  = HW'(h);
    cfg_mode = 2'(mode);
    cfg_m    = MW'(m);
    cfg_n    = ~MW'(n - m);
  endtask

  function automatic int exp_pulses(input int h, input int mode, input int m,
                                    input int n, input int w);
    int ticks;
    ticks = (h == 0) ? w : (2 * w) / (h + 1);
    if (mode != 0 && n != 0) return (ticks * m) / n;
    return ticks;
  endfunction

  task automatic next_pulse(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (out_en !== 1'b1);
  endtask

  task automatic run_window(input int h, input int mode, input int m, input int n,
                            input string req);
    int  w, pulses, toggles, expp;
    bit  dual;
    logic prev;
    @(negedge clk);
    set_cfg(h, mode, m, n);
    repeat (400) @(negedge clk);
    w = 4 * (h + 1) * ((n == 0) ? 1 : n);
    pulses = 0;
    toggles = 0;
    prev = out_tgl;
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      if (out_en) pulses++;
      if (out_tgl != prev) toggles++;
      prev = out_tgl;
    end
    expp = exp_pulses(h, mode, m, n, w);
    dual = (mode == 2) && (n != 0) && (m != n);
    check(pulses == expp, {req, " pulse count"}, pulses, expp);
    check(toggles == (dual ? pulses : 0), "R10 toggle count", toggles, dual ? pulses : 0);
  endtask

  task automatic gap_pattern(input int h);
    int g_prev, g;
    int lo, hi;
    lo = (h + 1) / 2;
    hi = lo + 1;
    @(negedge clk);
    set_cfg(h, 0, 0, 0);
    repeat (50) @(negedge clk);
    next_pulse(g_prev);
    next_pulse(g_prev);
    for (int i = 0; i < 6; i++) begin
      next_pulse(g);
      check(g == lo || g == hi, "R4 gap length", g, lo);
      check(g + g_prev == h + 1, "R4 gap pair sum", g + g_prev, h + 1);
      g_prev = g;
    end
  endtask

  initial begin
    int g, part;
    void'($urandom(32'd20240917));
    rst_n = 1'b0;
    set_cfg(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check(out_en == 1'b0, "R1 out_en in reset", int'(out_en), 0);
    check(out_tgl == 1'b0, "R1 out_tgl in reset", int'(out_tgl), 0);
    rst_n = 1'b1;

    run_window(0, 0, 0, 0, "R2");
    run_window(1, 0, 0, 0, "R3");
    run_window(3, 0, 0, 0, "R3");
    run_window(7, 0, 0, 0, "R3");
    run_window(2, 0, 0, 0, "R3 R4");
    gap_pattern(2);
    gap_pattern(4);
    gap_pattern(10);
    run_window(0, 1, 3, 7, "R5");
    run_window(5, 3, 2, 9, "R5");
    run_window(4, 1, 5, 5, "R5 R6");
    run_window(2, 1, 0, 0, "R6");
    run_window(0, 1, 0, 10, "R7");
    run_window(3, 0, 0, 0, "R7 resume");
    run_window(0, 2, 3, 8, "R10");
    run_window(1, 2, 5, 5, "R10");
    run_window(2, 1, 3, 8, "R10");

    // R8: change in the middle of a 20-cycle period
    @(negedge clk);
    set_cfg(0, 1, 1, 20);
    repeat (400) @(negedge clk);
    next_pulse(g);
    part = 0;
    repeat (5) begin
      @(negedge clk);
      part++;
    end
    set_cfg(3, 0, 0, 0);
    next_pulse(g);
    check(part + g == 20, "R8 old period kept", part + g, 20);
    next_pulse(g);
    check(g == 2, "R9 first new period", g, 2);
    // R9: change arriving in the very cycle of the pulse
    set_cfg(0, 1, 1, 5);
    next_pulse(g);
    check(g == 5, "R9 same-cycle load", g, 5);
    next_pulse(g);
    check(g == 5, "R9 steady after load", g, 5);

    for (int k = 0; k < 20; k++) begin
      int h, mode, n, m;
      h    = $urandom_range(15, 0);
      mode = $urandom_range(3, 0);
      n    = $urandom_range(40, 1);
      m    = $urandom_range(n, 0);
      run_window(h, mode, m, n, "R3 R5 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end
endmodule